// File: doc/BRIEF.md
# Host-Timed Byte Program Sequencer

This block writes one byte into a parallel flash device that does no timing of its own. On a start request it latches a target address and a data byte. It then drives the device bus through a fixed sequence. First it writes a program-setup command. Next it writes the data byte to the target address. It then counts out the programming pulse itself and writes a program-verify command. Last it reads the byte back and compares it with the intended value.

If the read-back differs, the whole sequence runs again. It runs until the byte matches or the attempt cap is reached. Bus timing is reduced to fixed clock counts: one set-up cycle, a write strobe of parameterised length, one hold cycle, and a read strobe of parameterised length. The result comes back as a one-cycle done pulse that carries either pass or fail.

Top module: `byte_prog_seq`

## Requirements
- R1: While reset is held and after it is released, rsp_done, rsp_pass, rsp_fail and bus_drive are low, and bus_we_n, bus_oe_n and bus_ce_n are high.
- R2: Each attempt performs three bus writes and then one read, in this order: command 0x40, the requested data byte, command 0xC0, read-back.
- R3: In every write, bus_we_n is low for exactly WE_CYC consecutive cycles. Across the whole strobe, bus_drive is high, bus_dout is constant, and bus_addr equals the requested address without changing.
- R4: From the end of the data write's strobe to the start of the verify strobe, bus_we_n stays high for exactly PULSE_CYC + 4 cycles.
- R5: The read follows the verify write. bus_oe_n is low for exactly READ_CYC cycles, and the byte compared is the value on bus_din in the last of those cycles.
- R6: A matching read-back ends the operation. rsp_done and rsp_pass go high together for exactly one cycle, and rsp_fail stays low.
- R7: A mismatching read-back, while fewer than MAX_TRY attempts have run, starts a complete new attempt from the setup command.
- R8: After MAX_TRY mismatching attempts (25 by default), rsp_done and rsp_fail go high together for one cycle. No further attempt is started.
- R9: A start request that arrives while an operation is in progress has no effect on the address, data or attempt count of that operation. It does not start a second operation.
- R10: bus_we_n and bus_oe_n are never low in the same cycle, and bus_drive is low whenever bus_oe_n is low.
- R11: bus_ce_n is low during every write and read strobe of an operation, and it returns high once the operation ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse, accepted only when idle |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to program |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_pass | output | 1 | With done: read-back matched |
| rsp_fail | output | 1 | With done: attempt cap reached |
| bus_addr | output | ADDR_W | Device address |
| bus_dout | output | DATA_W | Data driven to the device |
| bus_din | input | DATA_W | Data read from the device |
| bus_drive | output | 1 | Controller drives the data lines |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_ce_n | output | 1 | Chip enable, active low |

## Verification
The bench keeps the default cap of 25 attempts. It shrinks the timing to WE_CYC=2, PULSE_CYC=5 and READ_CYC=2 and uses a 4-bit address, so each attempt lasts only a few tens of cycles. With those values it can sweep the number of bad read-backs the device model returns, from zero to past the cap. That covers every attempt count from 1 to 25 and both results, and checks the command order, the strobe widths and the pulse gap on every attempt. The model makes its byte correct only in the final read cycle, which pins down when the sample is taken. A stray start is injected into every operation.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PROG, S_PULSE, S_VERIFY, S_READ, S_CMP
  } seq_state_t;

  typedef enum logic [2:0] {
    B_IDLE, B_WSET, B_WSTB, B_WHLD, B_ROE
  } bus_phase_t;

  localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PGM_VERIFY = 8'hC0;
endpackage

// File: rtl/bps_bus_cycle.sv
module bps_bus_cycle
  import bps_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WE_CYC   = 3,
  parameter int READ_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [DATA_W-1:0] bus_din,
  output logic              we_n,
  output logic              oe_n,
  output logic              drive,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata,
  output logic              fin
);
  localparam int LEN_MAX = (WE_CYC > READ_CYC) ? WE_CYC : READ_CYC;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CYC - 1);

  bus_phase_t       ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= B_IDLE;
      cnt   <= '0;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      drive <= 1'b0;
      dout  <= '0;
      rdata <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (ph)
        B_IDLE: begin
          if (wr_go) begin
            ph    <= B_WSET;
            dout  <= wr_val;
            drive <= 1'b1;
          end else if (rd_go) begin
            ph   <= B_ROE;
            oe_n <= 1'b0;
            cnt  <= '0;
          end
        end
        B_WSET: begin
          ph   <= B_WSTB;
          we_n <= 1'b0;
          cnt  <= '0;
        end
        B_WSTB: begin
          if (cnt == WE_LAST) begin
            ph   <= B_WHLD;
            we_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        B_WHLD: begin
          ph    <= B_IDLE;
          drive <= 1'b0;
          fin   <= 1'b1;
        end
        B_ROE: begin
          if (cnt == RD_LAST) begin
            ph    <= B_IDLE;
            oe_n  <= 1'b1;
            rdata <= bus_din;
            fin   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= B_IDLE;
      endcase
    end
  end

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst) !(!we_n && !oe_n)); // R10
  AST_DRIVE_ON_STROBE: assert property (@(posedge clk) disable iff (rst) !we_n |-> drive); // R3
  AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst) (!we_n && $past(!we_n)) |-> $stable(dout)); // R3
endmodule

// File: rtl/bps_pulse_timer.sv
module bps_pulse_timer #(
  parameter int PULSE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic fin
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PULSE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == P_LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_FIN_AFTER_RUN: assert property (@(posedge clk) disable iff (rst) fin |-> $past(run)); // R4
endmodule

// File: rtl/bps_try_ctr.sv
module bps_try_ctr #(
  parameter int MAX_TRY = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int TRY_W = $clog2(MAX_TRY + 1);
  localparam logic [TRY_W-1:0] TRY_CAP = TRY_W'(MAX_TRY);

  logic [TRY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= TRY_W'(1);
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == TRY_CAP);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt <= TRY_CAP); // R8
  AST_INC_BELOW_CAP: assert property (@(posedge clk) disable iff (rst) inc |-> !last); // R8
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int WE_CYC    = 3,
  parameter int PULSE_CYC = 200,
  parameter int READ_CYC  = 3,
  parameter int MAX_TRY   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_done,
  output logic              rsp_pass,
  output logic              rsp_fail,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_drive,
  output logic              bus_we_n,
  output logic              bus_oe_n,
  output logic              bus_ce_n
);
  localparam logic [DATA_W-1:0] W_SETUP  = DATA_W'(CMD_PGM_SETUP);
  localparam logic [DATA_W-1:0] W_VERIFY = DATA_W'(CMD_PGM_VERIFY);

  seq_state_t        state_q, state_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_go, rd_go, pulse_go, pulse_fin, bus_fin;
  logic [DATA_W-1:0] wr_val, rd_data;
  logic              try_clr, try_inc, try_last;
  logic              res_pass, res_fail;

  always_comb begin
    state_n  = state_q;
    wr_go    = 1'b0;
    rd_go    = 1'b0;
    wr_val   = W_SETUP;
    pulse_go = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    res_pass = 1'b0;
    res_fail = 1'b0;
    case (state_q)
      S_IDLE: if (req_start) begin
        wr_go   = 1'b1;
        try_clr = 1'b1;
        state_n = S_SETUP;
      end
      S_SETUP: if (bus_fin) begin
        wr_go   = 1'b1;
        wr_val  = data_q;
        state_n = S_PROG;
      end
      S_PROG: if (bus_fin) begin
        pulse_go = 1'b1;
        state_n  = S_PULSE;
      end
      S_PULSE: if (pulse_fin) begin
        wr_go   = 1'b1;
        wr_val  = W_VERIFY;
        state_n = S_VERIFY;
      end
      S_VERIFY: if (bus_fin) begin
        rd_go   = 1'b1;
        state_n = S_READ;
      end
      S_READ: if (bus_fin) state_n = S_CMP;
      S_CMP: begin
        if (rd_data == data_q) begin
          res_pass = 1'b1;
          state_n  = S_IDLE;
        end else if (try_last) begin
          res_fail = 1'b1;
          state_n  = S_IDLE;
        end else begin
          try_inc = 1'b1;
          wr_go   = 1'b1;
          state_n = S_SETUP;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      rsp_done <= 1'b0;
      rsp_pass <= 1'b0;
      rsp_fail <= 1'b0;
      bus_ce_n <= 1'b1;
    end else begin
      state_q  <= state_n;
      rsp_done <= res_pass | res_fail;
      rsp_pass <= res_pass;
      rsp_fail <= res_fail;
      bus_ce_n <= (state_n == S_IDLE);
      if (state_q == S_IDLE && req_start) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  assign bus_addr = addr_q;

  bps_bus_cycle #(.DATA_W(DATA_W), .WE_CYC(WE_CYC), .READ_CYC(READ_CYC)) u_bus (
    .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .wr_val(wr_val),
    .bus_din(bus_din), .we_n(bus_we_n), .oe_n(bus_oe_n), .drive(bus_drive),
    .dout(bus_dout), .rdata(rd_data), .fin(bus_fin)
  );

  bps_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst), .go(pulse_go), .fin(pulse_fin)
  );

  bps_try_ctr #(.MAX_TRY(MAX_TRY)) u_try (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .last(try_last)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) !bus_we_n |-> $stable(bus_addr)); // R3
  AST_RESULT_ONE: assert property (@(posedge clk) disable iff (rst) rsp_done |-> (rsp_pass != rsp_fail)); // R6
  AST_RESULT_GATED: assert property (@(posedge clk) disable iff (rst) !rsp_done |-> (!rsp_pass && !rsp_fail)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R6
  AST_CE_ACTIVE: assert property (@(posedge clk) disable iff (rst) (!bus_we_n || !bus_oe_n) |-> !bus_ce_n); // R11
endmodule

// File: tb/byte_prog_seq_test.sv
module byte_prog_seq_test;
  localparam int AW = 4, DW = 8, WEC = 2, PC = 5, RC = 2, MT = 25;

  logic clk = 1'b0, rst = 1'b1;
  logic req_start = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_done, rsp_pass, rsp_fail, bus_drive, bus_we_n, bus_oe_n, bus_ce_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;

  always #10 clk = ~clk;

  byte_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .WE_CYC(WEC), .PULSE_CYC(PC),
                  .READ_CYC(RC), .MAX_TRY(MT)) uut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_data(req_data), .rsp_done(rsp_done), .rsp_pass(rsp_pass),
    .rsp_fail(rsp_fail), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_drive(bus_drive), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_ce_n(bus_ce_n)
  );

  int errors = 0, checks = 0, cyc = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;
  int fail_k = 0, nprog = 0, seq = 0, wlen = 0, olen = 0, rise_cyc = 0;
  logic pw = 1'b1, po = 1'b1;
  logic [DW-1:0] wd = '0;

  assign bus_din = (nprog > fail_k && olen == RC) ? exp_data : ~exp_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst) begin
      if (!bus_we_n || !bus_oe_n)
        chk(!(!bus_we_n && !bus_oe_n), "R10 strobe overlap", 1, 0);
      if (!bus_we_n) begin
        if (pw) begin
          wlen = 0;
          wd = bus_dout;
          chk(bus_ce_n == 1'b0, "R11 ce during write", bus_ce_n, 0);
          if (seq == 2) chk(cyc - rise_cyc == PC + 4, "R4 pulse gap", cyc - rise_cyc, PC + 4);
        end
        wlen++;
        chk(bus_drive && bus_dout == wd && bus_addr == exp_addr, "R3 write stable",
            {bus_drive, bus_dout, bus_addr}, {1'b1, wd, exp_addr});
      end else if (!pw) begin
        chk(wlen == WEC, "R3 strobe width", wlen, WEC);
        case (seq)
          0: chk(wd == 8'h40, "R2 setup cmd", wd, 8'h40);
          1: chk(wd == exp_data, "R2 data write", wd, exp_data);
          2: chk(wd == 8'hC0, "R2 verify cmd", wd, 8'hC0);
          default: chk(1'b0, "R2 write where read due", wd, 0);
        endcase
        if (seq == 1) begin
          nprog++;
          rise_cyc = cyc;
        end
        if (seq < 3) seq++;
      end
      if (!bus_oe_n) begin
        if (po) begin
          olen = 0;
          chk(seq == 3, "R5 read after verify", seq, 3);
          chk(bus_ce_n == 1'b0, "R11 ce during read", bus_ce_n, 0);
        end
        olen++;
        chk(!bus_drive, "R10 no drive on read", bus_drive, 0);
      end else if (!po) begin
        chk(olen == RC, "R5 read width", olen, RC);
        seq = 0;
      end
    end
    pw = bus_we_n;
    po = bus_oe_n;
  end

  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input int k);
    int exp_tries;
    bit exp_pass;
    exp_pass  = (k < MT);
    exp_tries = exp_pass ? k + 1 : MT;
    @(negedge clk);
    exp_addr = a; exp_data = d; fail_k = k; nprog = 0; seq = 0; olen = 0;
    req_start = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_start = 1'b0;
    repeat (10) @(negedge clk);
    // R9: stray start while busy
    req_start = 1'b1; req_addr = ~a; req_data = ~d;
    @(negedge clk);
    req_start = 1'b0;
    while (!rsp_done) @(negedge clk);
    if (exp_pass) chk(rsp_pass && !rsp_fail, "R6 pass result", {rsp_pass, rsp_fail}, 2'b10);
    else          chk(rsp_fail && !rsp_pass, "R8 fail result", {rsp_pass, rsp_fail}, 2'b01);
    chk(nprog == exp_tries, exp_pass ? "R7 attempt count" : "R8 attempt cap", nprog, exp_tries);
    @(negedge clk);
    chk(!rsp_done && !rsp_pass && !rsp_fail, "R6 one-cycle done", rsp_done, 0);
    repeat (8) @(negedge clk);
    chk(bus_ce_n && bus_we_n && bus_oe_n, "R9 no second op / R11 ce released",
        {bus_ce_n, bus_we_n, bus_oe_n}, 3'b111);
    chk(nprog == exp_tries, "R9 no extra attempt", nprog, exp_tries);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_done && !rsp_pass && !rsp_fail && !bus_drive && bus_we_n && bus_oe_n && bus_ce_n,
        "R1 reset state", {rsp_done, rsp_pass, rsp_fail, bus_drive, bus_we_n, bus_oe_n, bus_ce_n},
        7'b0000111);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_done && bus_we_n && bus_oe_n && bus_ce_n && !bus_drive, "R1 after reset",
        {rsp_done, bus_we_n, bus_oe_n, bus_ce_n, bus_drive}, 5'b01110);
    for (int k = 0; k <= MT + 1; k++)
      run_op(AW'(k * 7 + 3), DW'(k * 37 + 5), k);
    run_op(4'h0, 8'h00, 0);
    run_op(4'hF, 8'hFF, 3);
    run_op(4'hA, 8'h5A, MT - 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule